// File: doc/BRIEF.md
# Bitstream Header Clock-to-Data Ratio Selector

This block sits in the word path of a configuration loader. Each accepted 32-bit configuration word goes through to the output unchanged. While the words pass, the block counts them and samples two fixed header positions. One holds a two-bit security field. The other holds an active-low compression flag.

When the later of the two header words is accepted, the block combines both flags with the configured bus width (16 or 32 bit). From them it selects a clock-to-data ratio code and registers it, together with a width control bit, so that a downstream programming engine can apply them. A one-cycle done strobe marks that moment. If the stream ends before the header is complete, the block raises an error and publishes no ratio. A synchronous start input prepares the block for the next image.

Top module: `cdr_hdr_ratio_sel`

## Requirements
- R1: `wd_data_o` and `wd_valid_o` equal `wd_data_i` and `wd_valid_i` in the same cycle. Only words with `wd_valid_i` high are counted, starting at index 0 after reset or start.
- R2: The image is treated as encrypted when bits [3:2] of the word at index 69 are nonzero. Words at other indices never change this flag.
- R3: The image is treated as compressed when bit 1 of the word at index 229 is 0. When that bit is 1, the image is uncompressed.
- R4: Ratio codes are x1=0, x2=1, x4=2 and x8=3. An image that is neither encrypted nor compressed yields code 0 at either width.
- R5: With `wide_i`=0 (16-bit), a compressed image yields code 2 whether or not it is encrypted. An image that is encrypted only yields code 1.
- R6: With `wide_i`=1 (32-bit), a compressed image yields code 3 and an image that is encrypted only yields code 2. In both cases this is one above the 16-bit code.
- R7: `wide_o` takes the value of `wide_i` at the cycle word 229 is accepted, and it changes at no other time except start or reset.
- R8: `done_o` is high for exactly one cycle, the cycle after word 229 is accepted. In that same cycle `ratio_o` holds the new code and `ratio_vld_o` rises.
- R9: Once word 229 has been accepted, later words and `wd_last_i` leave `ratio_o`, `wide_o`, `ratio_vld_o` and `err_o` unchanged and produce no further `done_o`.
- R10: If a word with `wd_last_i` high is accepted at an index below 229, `err_o` rises in the next cycle. After that, `ratio_vld_o` and `done_o` stay 0 and `err_o` stays high until start or reset. A stream of exactly 230 words is not an error.
- R11: `start_i` high clears the word count, the encryption flag, `err_o`, `ratio_vld_o`, `ratio_o` and `wide_o` in the next cycle. A word presented in the same cycle as `start_i` is not counted.
- R12: After reset, `ratio_o`, `ratio_vld_o`, `wide_o`, `done_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous clear for a new image |
| wide_i | input | 1 | Bus width select: 1 = 32-bit, 0 = 16-bit |
| wd_valid_i | input | 1 | Word valid |
| wd_last_i | input | 1 | Final word of the image |
| wd_data_i | input | 32 | Configuration word |
| wd_valid_o | output | 1 | Passed-through word valid |
| wd_data_o | output | 32 | Passed-through configuration word |
| ratio_o | output | 2 | Registered ratio code |
| ratio_vld_o | output | 1 | Ratio code is valid |
| wide_o | output | 1 | Latched width control bit |
| done_o | output | 1 | One-cycle strobe when the ratio is decided |
| err_o | output | 1 | Sticky short-stream error |

## Verification
On every cycle, the assertions check these invariants:
- the done strobe lasts a single cycle and comes with a valid ratio;
- the error and the valid ratio exclude each other;
- the error and the published result hold until start;
- the counter stays within its saturation value;
- the encryption flag is frozen once index 69 has passed;
- a 32-bit result never carries the x2 code.

Only the bench's scenarios can show the following:
- that the code matches the flag and width combination;
- that the header indices and bit positions are the right ones;
- that valid gaps are skipped;
- that a 229-word stream fails while a 230-word stream passes;
- that a word arriving together with start is dropped.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  localparam int unsigned RATIO_W = 2;

  typedef enum logic [RATIO_W-1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

  // Base code from the flags; the 32-bit width steps any non-x1 code up by one.
  function automatic ratio_e pick_ratio(input logic enc, input logic cmp, input logic wide);
    logic [RATIO_W-1:0] code;
    if (!enc && !cmp) begin
      code = RATIO_X1;
    end else begin
      code = cmp ? RATIO_X4 : RATIO_X2;
      if (wide) code = code + 2'd1;
    end
    return ratio_e'(code);
  endfunction
endpackage

// File: rtl/cdr_word_counter.sv
module cdr_word_counter #(
  parameter int unsigned LAST_IDX = 229,
  localparam int unsigned SAT     = LAST_IDX + 1,
  localparam int unsigned CNT_W   = $clog2(SAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             acc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

  assign sat_o = (cnt_o == SAT_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_o <= '0;
    else if (clr_i)            cnt_o <= '0;
    else if (acc_i && !sat_o)  cnt_o <= cnt_o + 1'b1;
  end

  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= SAT_V);
  a_r9_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_o && !clr_i) |=> sat_o);
  a_r11_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/cdr_hdr_decode.sv
module cdr_hdr_decode #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned ENC_IDX = 69,
  parameter int unsigned ENC_LSB = 2,
  parameter int unsigned CMP_IDX = 229,
  parameter int unsigned CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic              last_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              enc_q_o,
  output logic              hit_cmp_o,
  output logic              cmp_now_o,
  output logic              short_end_o
);
  localparam logic [CNT_W-1:0] ENC_V = CNT_W'(ENC_IDX);
  localparam logic [CNT_W-1:0] CMP_V = CNT_W'(CMP_IDX);

  logic at_enc;
  assign at_enc      = take_i && (cnt_i == ENC_V);
  assign hit_cmp_o   = take_i && (cnt_i == CMP_V);
  assign cmp_now_o   = ~data_i[CMP_BIT];
  assign short_end_o = take_i && last_i && (cnt_i < CMP_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      enc_q_o <= 1'b0;
    else if (clr_i)  enc_q_o <= 1'b0;
    else if (at_enc) enc_q_o <= |data_i[ENC_LSB+1:ENC_LSB];
  end

  a_r2_enc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i > ENC_V && !clr_i) |=> $stable(enc_q_o));
  a_r10_short_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_end_o && hit_cmp_o));
endmodule

// File: rtl/cdr_result_reg.sv
module cdr_result_reg
  import cdr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               hit_i,
  input  logic               short_i,
  input  logic               enc_i,
  input  logic               cmp_i,
  input  logic               wide_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               vld_o,
  output logic               wide_o,
  output logic               done_o,
  output logic               err_o
);
  ratio_e ratio_nx;
  assign ratio_nx = pick_ratio(enc_i, cmp_i, wide_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_o <= '0; vld_o <= 1'b0; wide_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0;
    end else if (clr_i) begin
      ratio_o <= '0; vld_o <= 1'b0; wide_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0;
    end else begin
      done_o <= hit_i;
      if (hit_i) begin
        ratio_o <= ratio_nx;
        wide_o  <= wide_i;
        vld_o   <= 1'b1;
      end
      if (short_i) err_o <= 1'b1;
    end
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_done_has_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> vld_o);
  a_r10_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_o && vld_o));
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_i) |=> err_o);
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !clr_i) |=> ($stable(ratio_o) && $stable(wide_o) && vld_o));
  a_r6_wide_no_x2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && wide_o) |-> (ratio_o != RATIO_X2));
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!err_o && !vld_o && !done_o && !wide_o));
endmodule

// File: rtl/cdr_hdr_ratio_sel.sv
module cdr_hdr_ratio_sel
  import cdr_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENC_IDX = 69,
  parameter int unsigned ENC_LSB = 2,
  parameter int unsigned CMP_IDX = 229,
  parameter int unsigned CMP_BIT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               wide_i,
  input  logic               wd_valid_i,
  input  logic               wd_last_i,
  input  logic [DATA_W-1:0]  wd_data_i,
  output logic               wd_valid_o,
  output logic [DATA_W-1:0]  wd_data_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               ratio_vld_o,
  output logic               wide_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int unsigned CNT_W = $clog2(CMP_IDX + 2);

  logic [CNT_W-1:0] cnt;
  logic             sat, take, enc_q, hit_cmp, cmp_now, short_end;

  assign wd_valid_o = wd_valid_i;
  assign wd_data_o  = wd_data_i;

  // A word is taken while counting is still open and no error is pending.
  assign take = wd_valid_i && !start_i && !err_o && !sat;

  cdr_word_counter #(.LAST_IDX(CMP_IDX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .acc_i(take),
    .cnt_o(cnt), .sat_o(sat)
  );

  cdr_hdr_decode #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ENC_IDX(ENC_IDX), .ENC_LSB(ENC_LSB),
    .CMP_IDX(CMP_IDX), .CMP_BIT(CMP_BIT)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .take_i(take), .last_i(wd_last_i),
    .cnt_i(cnt), .data_i(wd_data_i), .enc_q_o(enc_q), .hit_cmp_o(hit_cmp),
    .cmp_now_o(cmp_now), .short_end_o(short_end)
  );

  cdr_result_reg u_res (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .hit_i(hit_cmp), .short_i(short_end),
    .enc_i(enc_q), .cmp_i(cmp_now), .wide_i(wide_i), .ratio_o(ratio_o),
    .vld_o(ratio_vld_o), .wide_o(wide_o), .done_o(done_o), .err_o(err_o)
  );

  a_r8_done_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmp && !start_i) |=> done_o);
  a_r10_err_after_short: assert property (@(posedge clk) disable iff (!rst_n)
    (short_end && !start_i) |=> err_o);
  a_r1_pass: assert property (@(posedge clk) disable iff (!rst_n)
    sat |-> !hit_cmp && !short_end);
endmodule

// File: tb/test_cdr_hdr_ratio_sel.sv
module test_cdr_hdr_ratio_sel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, wide_i = 1'b0, wd_valid_i = 1'b0, wd_last_i = 1'b0;
  logic [31:0] wd_data_i = '0;
  logic        wd_valid_o, ratio_vld_o, wide_o, done_o, err_o;
  logic [31:0] wd_data_o;
  logic [1:0]  ratio_o;

  always #2 clk = ~clk;

  cdr_hdr_ratio_sel i_cdr_hdr_ratio_sel (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
    .wd_valid_i(wd_valid_i), .wd_last_i(wd_last_i), .wd_data_i(wd_data_i),
    .wd_valid_o(wd_valid_o), .wd_data_o(wd_data_o), .ratio_o(ratio_o),
    .ratio_vld_o(ratio_vld_o), .wide_o(wide_o), .done_o(done_o), .err_o(err_o)
  );

  typedef struct packed { logic is_err; logic [1:0] ratio; logic wide; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit finished = 0, mon_on = 0;
  logic err_prev = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Expected code from the requirement table (R4, R5, R6).
  function automatic logic [1:0] exp_ratio(input logic [1:0] enc2, input logic cmpb, input logic wide);
    if (!cmpb)            return wide ? 2'd3 : 2'd2;
    else if (enc2 != 2'b0) return wide ? 2'd2 : 2'd1;
    else                  return 2'd0;
  endfunction

  function automatic logic [31:0] word_val(input int i, input logic [1:0] enc2, input logic cmpb);
    logic [31:0] w;
    w = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    if (i == 69)  w[3:2] = enc2;
    if (i == 229) w[1]   = cmpb;
    return w;
  endfunction

  task automatic drive_word(input logic [31:0] d, input logic last);
    wd_data_i = d; wd_valid_i = 1'b1; wd_last_i = last;
    #1;
    check(wd_data_o == d && wd_valid_o, "R1 pass-through", int'(wd_data_o), int'(d));
    @(negedge clk);
    wd_valid_i = 1'b0; wd_last_i = 1'b0;
  endtask

  // cmpb is the raw bit 1 of word 229 (0 = compressed, R3).
  task automatic send_image(input int n, input logic [1:0] enc2, input logic cmpb,
                            input logic wide, input int gap_every);
    exp_t e;
    wide_i = wide;
    e.is_err = (n < 230);
    e.ratio  = e.is_err ? 2'd0 : exp_ratio(enc2, cmpb, wide);
    e.wide   = wide;
    exp_q.push_back(e);
    for (int i = 0; i < n; i++) begin
      drive_word(word_val(i, enc2, cmpb), i == n - 1);
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8/R10 result produced", exp_q.size(), 0);
  endtask

  task automatic do_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    check(!err_o && !ratio_vld_o && !wide_o && ratio_o == 2'd0, "R11 start clears",
          {err_o, ratio_vld_o, wide_o, ratio_o}, 0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (done_o) begin
        if (exp_q.size() == 0) check(0, "R8/R9 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(!e.is_err, "R10 done instead of error", 1, 0);
          check(ratio_o == e.ratio, "R4/R5/R6 ratio code", ratio_o, e.ratio);
          check(wide_o == e.wide, "R7 width bit", wide_o, e.wide);
          check(ratio_vld_o, "R8 valid with done", ratio_vld_o, 1);
        end
      end
      if (err_o && !err_prev) begin
        if (exp_q.size() == 0) check(0, "R10 unexpected error", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.is_err, "R10 error flag", 1, 0);
          check(!ratio_vld_o, "R10 no ratio on error", ratio_vld_o, 0);
        end
      end
      err_prev <= err_o;
    end
  end

  initial begin
    logic [1:0] r_keep;
    repeat (3) @(negedge clk);
    check(ratio_o == 0 && !ratio_vld_o && !wide_o && !done_o && !err_o, "R12 reset state",
          {ratio_o, ratio_vld_o, wide_o, done_o, err_o}, 0);
    rst_n = 1'b1; mon_on = 1;
    @(negedge clk);

    // R4 plain image, both widths
    send_image(230, 2'b00, 1'b1, 1'b0, 0); do_start();
    send_image(230, 2'b00, 1'b1, 1'b1, 7); do_start();
    // R5 16-bit
    send_image(230, 2'b01, 1'b1, 1'b0, 0); do_start();
    send_image(230, 2'b00, 1'b0, 1'b0, 5); do_start();
    send_image(230, 2'b11, 1'b0, 1'b0, 0); do_start();
    // R6 32-bit, R2 field values 10 and 01
    send_image(230, 2'b10, 1'b1, 1'b1, 0); do_start();
    send_image(230, 2'b00, 1'b0, 1'b1, 3); do_start();
    send_image(230, 2'b01, 1'b0, 1'b1, 0);

    // R9 / R7: extra words and a width change after the decision
    r_keep = ratio_o;
    wide_i = 1'b0;
    for (int i = 0; i < 6; i++) drive_word(32'h0, i == 5);
    repeat (2) @(negedge clk);
    check(ratio_o == r_keep && wide_o && ratio_vld_o && !err_o, "R9 later words ignored",
          ratio_o, r_keep);
    do_start();

    // R10 boundary: 229 words is short, error sticks
    send_image(229, 2'b00, 1'b1, 1'b1, 0);
    drive_word(32'h0, 1'b1);
    @(negedge clk);
    check(err_o && !ratio_vld_o, "R10 error sticky", err_o, 1);
    do_start();
    send_image(10, 2'b01, 1'b0, 1'b0, 2); do_start();

    // R11 start mid-image, then a fresh image is judged alone
    for (int i = 0; i < 100; i++) drive_word(word_val(i, 2'b11, 1'b0), 1'b0);
    do_start();
    send_image(230, 2'b00, 1'b1, 1'b1, 0); do_start();

    // R11 word alongside start is dropped: 1 + 229 words must be short
    wd_data_i = 32'h0; wd_valid_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    wd_valid_i = 1'b0; start_i = 1'b0;
    send_image(229, 2'b00, 1'b1, 1'b0, 0);
    do_start();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule